// File: doc/BRIEF.md
# Trimmed Reference Soft-Start Ramp

This block produces the digital set-point that feeds the main error amplifier's reference DAC. The code is one millivolt per LSB. While enable is low the code sits at zero. Once enable is high, each pulse of an external timebase tick raises the code by a fixed step of 39 mV. The steps go on until the code reaches its target, where the last step is clamped so that it lands exactly on the target. A done flag then rises, and the code holds the target.

The target is a nominal 2500 mV moved by a signed 4-bit trim nibble at 16 mV per LSB. This gives a settable end point from 2372 mV to 2612 mV, roughly ±5 % of nominal. A tick period of about 125 µs gives a ramp of about 8 ms. The ramp never jumps and never decreases while the trim is steady, so the amplifier is not driven into saturation at start-up. If the trim changes after the ramp has finished, the output takes the new target on the next tick.

Top module: `vref_ramp_gen`

## Requirements
- R1: During and right after reset, `ref_code` is 0 and `ramp_done` is 0.
- R2: `trim_code` is a 4-bit two's complement offset. The target in mV is 2500 + 16 × trim, so 1000 gives 2372, 0000 gives 2500 and 0111 gives 2612. `ref_code` is in units of 1 mV.
- R3: While enabled and not done, each clock edge that samples `step_tick` high raises `ref_code` by 39, unless that step would reach or pass the target.
- R4: A step that would reach or pass the target sets `ref_code` to the target exactly, and `ramp_done` rises on that same edge. `ref_code` never exceeds the largest possible target.
- R5: `ref_code` changes only on edges where `step_tick` is sampled high while enabled, or on edges where enable is sampled low.
- R6: On the first edge that samples `ramp_en` low, `ref_code` becomes 0 and `ramp_done` becomes 0.
- R7: A new enable after a disable restarts the ramp from 0, so the first tick gives 39.
- R8: Once done, each tick loads the current target, so a trim change after completion shows at the output on the next tick.
- R9: With a steady trim, the ramp takes 61, 65 and 67 ticks to complete for trims 1000, 0000 and 0111.
- R10: While ramping with a steady trim, `ref_code` never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ramp_en | input | 1 | Enable; low clears the ramp |
| trim_code | input | 4 | Signed trim, 16 mV per LSB |
| step_tick | input | 1 | Single-cycle timebase pulse, one step per pulse |
| ref_code | output | 12 | Reference code, 1 mV per LSB |
| ramp_done | output | 1 | High once the code has reached the target |

## Verification
A wrong step size or a bad clamp would show on the code one edge after the offending tick. The tick count to completion for each trim extreme would also move away from 61, 65 or 67. A done flag stuck low after completion would leave a later trim change unseen at the output on the next tick. A stale code after a disable would show as a non-zero value on the edge after enable falls, or as a restart that does not begin at 39. The bench model compares code and flag on every clock, so any such fault surfaces within one cycle of its cause.

// File: rtl/vref_pkg.sv
package vref_pkg;

  // Nominal target shifted by a signed trim count.
  function automatic int trimmed_target(input int nom_mv, input int lsb_mv, input int trim_s);
    return nom_mv + lsb_mv * trim_s;
  endfunction

  // One ramp step toward the target, clamped so the target is never passed.
  function automatic int step_toward(input int cur, input int tgt, input int step);
    if (cur + step >= tgt) return tgt;
    return cur + step;
  endfunction

endpackage

// File: rtl/vref_trim_target.sv
module vref_trim_target #(
  parameter int CODE_W      = 12,
  parameter int TRIM_W      = 4,
  parameter int NOM_MV      = 2500,
  parameter int TRIM_LSB_MV = 16
) (
  input  logic [TRIM_W-1:0] trim_code,
  output logic [CODE_W-1:0] target_mv
);
  import vref_pkg::*;

  int trim_s;

  always_comb begin
    trim_s    = int'($signed(trim_code));
    target_mv = CODE_W'(trimmed_target(NOM_MV, TRIM_LSB_MV, trim_s));
  end
endmodule

// File: rtl/vref_step_calc.sv
module vref_step_calc #(
  parameter int CODE_W  = 12,
  parameter int STEP_MV = 39
) (
  input  logic [CODE_W-1:0] cur_code,
  input  logic [CODE_W-1:0] target_mv,
  output logic [CODE_W-1:0] next_code,
  output logic              reach
);
  import vref_pkg::*;

  always_comb begin
    next_code = CODE_W'(step_toward(int'(cur_code), int'(target_mv), STEP_MV));
    reach     = (next_code == target_mv);
  end
endmodule

// File: rtl/vref_ramp_gen.sv
module vref_ramp_gen #(
  parameter int CODE_W      = 12,
  parameter int TRIM_W      = 4,
  parameter int NOM_MV      = 2500,
  parameter int TRIM_LSB_MV = 16,
  parameter int STEP_MV     = 39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ramp_en,
  input  logic [TRIM_W-1:0] trim_code,
  input  logic              step_tick,
  output logic [CODE_W-1:0] ref_code,
  output logic              ramp_done
);
  logic [CODE_W-1:0] code_q;
  logic              done_q;
  logic [CODE_W-1:0] target_mv;
  logic [CODE_W-1:0] step_next;
  logic              step_reach;
  logic              tick_fire;
  logic              ramp_active;

  vref_trim_target #(
    .CODE_W(CODE_W), .TRIM_W(TRIM_W), .NOM_MV(NOM_MV), .TRIM_LSB_MV(TRIM_LSB_MV)
  ) u_target (
    .trim_code(trim_code),
    .target_mv(target_mv)
  );

  vref_step_calc #(
    .CODE_W(CODE_W), .STEP_MV(STEP_MV)
  ) u_step (
    .cur_code (code_q),
    .target_mv(target_mv),
    .next_code(step_next),
    .reach    (step_reach)
  );

  assign tick_fire   = ramp_en & step_tick;
  assign ramp_active = ramp_en & ~done_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !ramp_en) begin
      code_q <= '0;
      done_q <= 1'b0;
    end else if (tick_fire) begin
      if (ramp_active) begin
        code_q <= step_next;
        done_q <= step_reach;
      end else begin
        code_q <= target_mv;
      end
    end
  end

  assign ref_code  = code_q;
  assign ramp_done = done_q;
endmodule

// File: rtl/vref_ramp_chk.sv
module vref_ramp_chk #(
  parameter int CODE_W      = 12,
  parameter int TRIM_W      = 4,
  parameter int NOM_MV      = 2500,
  parameter int TRIM_LSB_MV = 16,
  parameter int STEP_MV     = 39
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ramp_en,
  input logic [TRIM_W-1:0] trim_code,
  input logic              step_tick,
  input logic [CODE_W-1:0] ref_code,
  input logic              ramp_done,
  input logic [CODE_W-1:0] target_mv
);
  localparam int MAX_TARGET = NOM_MV + ((2 ** (TRIM_W - 1)) - 1) * TRIM_LSB_MV;

  // R6
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ramp_en) |-> (ref_code == '0 && !ramp_done));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ramp_en) && !$past(step_tick)) |-> $stable(ref_code));

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ramp_en) && !$past(ramp_done)) |-> (int'(ref_code) <= int'($past(ref_code)) + STEP_MV));

  // R4
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ref_code) <= MAX_TARGET);

  // R4
  done_on_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ramp_done) |-> (ref_code == $past(target_mv)));

  // R8
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ramp_en && step_tick && ramp_done) |-> (ref_code == $past(target_mv)));

  // R10
  mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ramp_en) && !$past(ramp_done) && ($past(trim_code) == $past(trim_code, 2)))
      |-> (ref_code >= $past(ref_code)));
endmodule

bind vref_ramp_gen vref_ramp_chk #(
  .CODE_W(CODE_W), .TRIM_W(TRIM_W), .NOM_MV(NOM_MV),
  .TRIM_LSB_MV(TRIM_LSB_MV), .STEP_MV(STEP_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ramp_en(ramp_en), .trim_code(trim_code),
  .step_tick(step_tick), .ref_code(ref_code), .ramp_done(ramp_done),
  .target_mv(target_mv)
);

// File: tb/test_vref_ramp_gen.sv
module test_vref_ramp_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ramp_en = 1'b0;
  logic [3:0] trim_code = 4'b0000;
  logic       step_tick = 1'b0;
  logic [11:0] ref_code;
  logic       ramp_done;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string tag = "R1";

  // behavioural reference state
  int m_code = 0;
  bit m_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vref_ramp_gen i_vref_ramp_gen (
    .clk(clk), .rst_n(rst_n), .ramp_en(ramp_en), .trim_code(trim_code),
    .step_tick(step_tick), .ref_code(ref_code), .ramp_done(ramp_done)
  );

  function automatic int goal(input logic [3:0] t);
    int s;
    s = (t[3]) ? int'(t) - 16 : int'(t);
    return 2500 + s * 16;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !ramp_en) begin
      m_code = 0; m_done = 0;
    end else if (step_tick) begin
      if (m_done) m_code = goal(trim_code);
      else if (m_code + 39 >= goal(trim_code)) begin
        m_code = goal(trim_code); m_done = 1;
      end else m_code = m_code + 39;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    check(tag, int'(ref_code), m_code);
    check(tag, int'(ramp_done), int'(m_done));
    if (cyc > WATCHDOG) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic do_tick(input int gap);
    @(negedge clk); step_tick = 1'b1;
    @(negedge clk); step_tick = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic ramp_count(input logic [3:0] t, input int exp_ticks, input string rq);
    int n = 0;
    @(negedge clk); ramp_en = 1'b0; trim_code = t;
    @(negedge clk); ramp_en = 1'b1;
    while (!ramp_done && n < 200) begin
      do_tick(n % 3);
      n++;
    end
    check(rq, n, exp_ticks);
    check("R2", int'(ref_code), goal(t));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(ref_code), 0);
    check("R1", int'(ramp_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(ref_code), 0);

    // ticks with enable low do nothing (R5)
    tag = "R5";
    do_tick(1); do_tick(0);
    check("R5", int'(ref_code), 0);

    // nominal ramp (R3, R4, R9)
    tag = "R3";
    ramp_count(4'b0000, 65, "R9");
    // held with no tick (R5)
    tag = "R5";
    repeat (5) @(negedge clk);
    check("R5", int'(ref_code), 2500);

    tag = "R9";
    ramp_count(4'b0111, 67, "R9");
    ramp_count(4'b1000, 61, "R9");

    // trim change after completion (R8)
    tag = "R8";
    trim_code = 4'b0011;
    @(negedge clk);
    check("R8", int'(ref_code), 2372);
    do_tick(0);
    check("R8", int'(ref_code), 2548);
    trim_code = 4'b1111;
    do_tick(2);
    check("R8", int'(ref_code), 2484);

    // disable mid-ramp then restart (R6, R7)
    tag = "R6";
    @(negedge clk); ramp_en = 1'b0; trim_code = 4'b0000;
    @(negedge clk); ramp_en = 1'b1;
    repeat (10) do_tick(1);
    check("R3", int'(ref_code), 390);
    ramp_en = 1'b0;
    @(negedge clk);
    check("R6", int'(ref_code), 0);
    check("R6", int'(ramp_done), 0);
    tag = "R7";
    ramp_en = 1'b1;
    do_tick(0);
    check("R7", int'(ref_code), 39);

    // trim moved mid-ramp, model tracks (R10 region)
    tag = "R10";
    repeat (20) do_tick(0);
    trim_code = 4'b0101;
    repeat (60) do_tick(1);
    check("R4", int'(ref_code), goal(4'b0101));
    check("R4", int'(ramp_done), 1);

    // tick with enable dropping together (R6)
    tag = "R6";
    @(negedge clk); ramp_en = 1'b0; step_tick = 1'b1;
    @(negedge clk); step_tick = 1'b0;
    check("R6", int'(ref_code), 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule